// File: doc/BRIEF.md
# NAND Flash Controller Front End

This block sits between a simple register bus and one 8- or 16-bit NAND device. Software sends commands, addresses and data words by writing registers; each write is queued in a small write buffer and played out on the device pins as one latch-qualified write strobe. A single device read is requested by writing any value to a request register. The controller then runs one read strobe and leaves the sampled word in a result register, raising a sticky ready flag.

For bulk transfers the block also runs page sequences covering one error-correction section. A page read issues every read strobe of the section by itself. A page write counts the data words software pushes. Every word of either sequence is presented on a side stream for a separate error-correction engine, which also receives a clear pulse from a self-clearing reset bit. Strobe low times come from programmable delay fields. The ready/busy pin is synchronized and its rising edge raises an interrupt flag.

Register map (word addresses on `reg_addr`): 0 control, 1 status (read only), 2 interrupt flags, 3 reset, 4 page start, 5 command push, 6 address push, 7 data push, 8 read request, 9 read result. Control layout: bit 0 selects a 512-byte section (0 gives 256 bytes), bit 1 selects a 16-bit bus, bits 5:2 hold the read delay, bits 9:6 hold the write delay.

Top module: `nand_ctrl_front`

## Requirements
- R1: After reset the status register reads 0x10 with the ready/busy pin low, the interrupt register reads 0, the reset register reads 0, both strobes are high and neither latch enable is set.
- R2: A push to address 5, 6 or 7 gives exactly one write strobe with the command latch (address 5), the address latch (address 6) or neither (address 7) held; the bus carries the low byte (or the full word for a data push in 16-bit mode); the write strobe stays low for write delay + 1 cycles and is high for at least one cycle after it.
- R3: The write buffer holds 4 entries; status bit 1 is set while it is full and bit 4 while it is empty; a push while full is dropped and sets interrupt bit 1.
- R4: Writing any value to address 8 gives one read strobe low for read delay + 1 cycles; the sampled word (low byte only in 8-bit mode) appears at address 9 and interrupt bit 3 is set.
- R5: Interrupt bits are cleared by writing 1 to them; writing 0 leaves them unchanged.
- R6: Interrupt bit 2 is set when the write buffer drains to empty.
- R7: Status bit 0 follows the ready/busy pin through a two-flop synchronizer; its rising edge sets interrupt bit 0.
- R8: Writing 1 to bit 0 of address 3 makes that bit read 1 until the reset is taken, then it clears itself; taking it gives one cycle of `ecc_clr` and zeroes the section counter.
- R9: Writing 1 to bit 0 of address 4 sets status bit 3 and makes the block issue one read per bus word of the section (256 or 512 bytes divided by the bus width in bytes), each word appearing once on `ecc_valid`/`ecc_word`; status bit 3 then clears and interrupt bit 3 is not set.
- R10: Writing 1 to bit 1 of address 4 sets status bit 2; data words written out are counted and shown on the error-correction stream; after one section of words status bit 2 clears and interrupt bit 4 is set. A page read and a page write are never pending together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 16 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 16 | Data bus in |
| nand_rb | input | 1 | Device ready/busy, high when ready |
| ecc_clr | output | 1 | Clear pulse to the error-correction engine |
| ecc_valid | output | 1 | Section word valid on the stream |
| ecc_word | output | 16 | Section word transferred |

## Verification
A corrupted buffer pointer or count shows at the pins as a missing, repeated or reordered strobe at the next drain, and at once in the full and empty status bits. A wrong strobe counter shows within one strobe as a low time that does not match the delay field. A wrong section counter shows only at the end of a page, as a stream with the wrong number of beats or a pending bit that clears too early or never, so the page checks count every beat over whole sections of both sizes and both widths.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

   typedef enum logic [1:0] {
      OP_CMD  = 2'd0,
      OP_ADDR = 2'd1,
      OP_DATA = 2'd2,
      OP_READ = 2'd3
   } nfc_op_e;

   localparam logic [3:0] A_CTRL  = 4'd0;
   localparam logic [3:0] A_STAT  = 4'd1;
   localparam logic [3:0] A_IRQ   = 4'd2;
   localparam logic [3:0] A_RST   = 4'd3;
   localparam logic [3:0] A_PAGE  = 4'd4;
   localparam logic [3:0] A_CMD   = 4'd5;
   localparam logic [3:0] A_ADDR  = 4'd6;
   localparam logic [3:0] A_DWR   = 4'd7;
   localparam logic [3:0] A_DRD   = 4'd8;
   localparam logic [3:0] A_RDATA = 4'd9;

   localparam int FLAG_N = 5;

endpackage

// File: rtl/nfc_wbuf.sv
module nfc_wbuf #(
   parameter int DEPTH = 4,
   parameter int W     = 18
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("nfc_wbuf: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt;

   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);
   assign dout  = mem[rp];

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // R3
   wbuf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!full || pop));
   // R3
   wbuf_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/nfc_pin_seq.sv
module nfc_pin_seq
   import nfc_pkg::*;
#(
   parameter int DQ_W  = 16,
   parameter int DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  nfc_op_e          op,
   input  logic [DQ_W-1:0]  wdata,
   input  logic             wide,
   input  logic [DLY_W-1:0] wr_dly,
   input  logic [DLY_W-1:0] rd_dly,
   output logic             busy,
   output logic             done,
   output nfc_op_e          done_op,
   output logic [DQ_W-1:0]  done_word,
   output logic             nand_cle,
   output logic             nand_ale,
   output logic             nand_we_n,
   output logic             nand_re_n,
   output logic [DQ_W-1:0]  nand_dq_o,
   output logic             nand_dq_oe,
   input  logic [DQ_W-1:0]  nand_dq_i
);
   typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} seq_st_e;

   seq_st_e          state;
   nfc_op_e          op_q;
   logic [DQ_W-1:0]  word_q, rd_q;
   logic [DLY_W-1:0] cnt;
   logic [DQ_W-1:0]  byte_out, data_out, in_fmt;

   generate
      if (DQ_W > 8) begin : g_wide_bus
         assign byte_out = {{(DQ_W-8){1'b0}}, wdata[7:0]};
         assign data_out = wide ? wdata : byte_out;
         assign in_fmt   = wide ? nand_dq_i : {{(DQ_W-8){1'b0}}, nand_dq_i[7:0]};
      end else begin : g_byte_bus
         logic unused_wide;
         assign unused_wide = wide;
         assign byte_out = wdata;
         assign data_out = wdata;
         assign in_fmt   = nand_dq_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         op_q   <= OP_CMD;
         word_q <= '0;
         rd_q   <= '0;
         cnt    <= '0;
      end else begin
         case (state)
            S_IDLE: if (start) begin
               state  <= S_LOW;
               op_q   <= op;
               word_q <= (op == OP_DATA) ? data_out : byte_out;
               cnt    <= (op == OP_READ) ? rd_dly : wr_dly;
            end
            S_LOW: begin
               if (cnt == '0) begin
                  state <= S_HIGH;
                  if (op_q == OP_READ) rd_q <= in_fmt;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            S_HIGH:  state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign busy       = (state != S_IDLE);
   assign done       = (state == S_HIGH);
   assign done_op    = op_q;
   assign done_word  = (op_q == OP_READ) ? rd_q : word_q;
   assign nand_we_n  = !((state == S_LOW) && (op_q != OP_READ));
   assign nand_re_n  = !((state == S_LOW) && (op_q == OP_READ));
   assign nand_cle   = busy && (op_q == OP_CMD);
   assign nand_ale   = busy && (op_q == OP_ADDR);
   assign nand_dq_oe = busy && (op_q != OP_READ);
   assign nand_dq_o  = word_q;

   // R2
   strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nand_we_n) |-> (cnt == $past(wr_dly)));
   // R2
   strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_HIGH) |=> (nand_we_n && nand_re_n));

endmodule

// File: rtl/nfc_rb_sync.sv
module nfc_rb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rb_pin,
   output logic rb_level,
   output logic rb_rise
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("nfc_rb_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], rb_pin};
         prev  <= chain[STAGES-1];
      end
   end

   assign rb_level = chain[STAGES-1];
   assign rb_rise  = chain[STAGES-1] && !prev;

endmodule

// File: rtl/nand_ctrl_front.sv
module nand_ctrl_front
   import nfc_pkg::*;
#(
   parameter int DQ_W       = 16,
   parameter int WBUF_DEPTH = 4,
   parameter int DLY_W      = 4,
   parameter int SECT_BIG   = 512,
   parameter int RB_STAGES  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic [3:0]      reg_addr,
   input  logic [15:0]     reg_wdata,
   output logic [15:0]     reg_rdata,
   output logic            nand_cle,
   output logic            nand_ale,
   output logic            nand_we_n,
   output logic            nand_re_n,
   output logic [DQ_W-1:0] nand_dq_o,
   output logic            nand_dq_oe,
   input  logic [DQ_W-1:0] nand_dq_i,
   input  logic            nand_rb,
   output logic            ecc_clr,
   output logic            ecc_valid,
   output logic [DQ_W-1:0] ecc_word
);
   localparam int REG_W = 16;
   localparam int ENT_W = 2 + DQ_W;
   localparam int CNT_W = $clog2(SECT_BIG) + 1;
   localparam int RD_LO = 2;
   localparam int WR_LO = 2 + DLY_W;

   generate
      if (DQ_W != 8 && DQ_W != 16) begin : g_bad_width
         $error("nand_ctrl_front: DQ_W must be 8 or 16");
      end
      if (WR_LO + DLY_W > REG_W) begin : g_bad_dly
         $error("nand_ctrl_front: delay fields do not fit the control register");
      end
   endgenerate

   // control state
   logic             pg512, wide, wide_in;
   logic [DLY_W-1:0] rd_dly, wr_dly;
   logic [FLAG_N-1:0] irq, irq_set, irq_clr;
   logic             rst_pend, pg_rd, pg_wr, auto_q, empty_q;
   logic [CNT_W-1:0] pg_cnt, sect_full, sect_last;
   logic [DQ_W-1:0]  rd_reg;

   // write buffer
   logic             push_req, push_ok, ovf, pop, wb_full, wb_empty;
   logic [ENT_W-1:0] wb_din, wb_dout;
   nfc_op_e          push_op;

   // pin sequencer
   logic             seq_start, seq_busy, seq_done, auto_go;
   nfc_op_e          seq_op, done_op;
   logic [DQ_W-1:0]  done_word;
   logic             page_beat, page_end, man_rd;
   logic             rb_level, rb_rise;

   generate
      if (DQ_W > 8) begin : g_sel_wide
         assign wide_in = reg_wdata[1];
      end else begin : g_fix_narrow
         assign wide_in = 1'b0;
      end
   endgenerate

   always_comb begin
      push_req = 1'b0;
      push_op  = OP_DATA;
      if (reg_wr) begin
         case (reg_addr)
            A_CMD:   begin push_req = 1'b1; push_op = OP_CMD;  end
            A_ADDR:  begin push_req = 1'b1; push_op = OP_ADDR; end
            A_DWR:   begin push_req = 1'b1; push_op = OP_DATA; end
            A_DRD:   begin push_req = 1'b1; push_op = OP_READ; end
            default: ;
         endcase
      end
   end

   assign pop       = !seq_busy && !wb_empty;
   assign push_ok   = push_req && (!wb_full || pop);
   assign ovf       = push_req && wb_full && !pop;
   assign wb_din    = {push_op, reg_wdata[DQ_W-1:0]};
   assign auto_go   = !seq_busy && wb_empty && pg_rd && !rst_pend;
   assign seq_start = pop || auto_go;
   assign seq_op    = pop ? nfc_op_e'(wb_dout[ENT_W-1 -: 2]) : OP_READ;

   nfc_wbuf #(.DEPTH(WBUF_DEPTH), .W(ENT_W)) u_wbuf (
      .clk(clk), .rst_n(rst_n), .push(push_ok), .pop(pop), .din(wb_din),
      .dout(wb_dout), .full(wb_full), .empty(wb_empty)
   );

   nfc_pin_seq #(.DQ_W(DQ_W), .DLY_W(DLY_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(seq_start), .op(seq_op),
      .wdata(wb_dout[DQ_W-1:0]), .wide(wide), .wr_dly(wr_dly), .rd_dly(rd_dly),
      .busy(seq_busy), .done(seq_done), .done_op(done_op), .done_word(done_word),
      .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
      .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
      .nand_dq_i(nand_dq_i)
   );

   nfc_rb_sync #(.STAGES(RB_STAGES)) u_rb (
      .clk(clk), .rst_n(rst_n), .rb_pin(nand_rb), .rb_level(rb_level), .rb_rise(rb_rise)
   );

   // section bookkeeping
   assign sect_full = pg512 ? CNT_W'(SECT_BIG) : CNT_W'(SECT_BIG / 2);
   assign sect_last = (sect_full >> wide) - 1'b1;
   assign page_beat = seq_done && (((done_op == OP_READ) && auto_q) ||
                                   ((done_op == OP_DATA) && pg_wr));
   assign page_end  = page_beat && (pg_cnt == sect_last);
   assign man_rd    = seq_done && (done_op == OP_READ) && !auto_q;
   assign ecc_clr   = rst_pend && !seq_busy;
   assign ecc_valid = page_beat;
   assign ecc_word  = done_word;

   assign irq_set = {page_end && (done_op == OP_DATA), man_rd,
                     wb_empty && !empty_q, ovf, rb_rise};
   assign irq_clr = (reg_wr && reg_addr == A_IRQ) ? reg_wdata[FLAG_N-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pg512    <= 1'b0;
         wide     <= 1'b0;
         rd_dly   <= '0;
         wr_dly   <= '0;
         irq      <= '0;
         rst_pend <= 1'b0;
         pg_rd    <= 1'b0;
         pg_wr    <= 1'b0;
         pg_cnt   <= '0;
         rd_reg   <= '0;
         auto_q   <= 1'b0;
         empty_q  <= 1'b1;
      end else begin
         empty_q <= wb_empty;
         irq     <= (irq & ~irq_clr) | irq_set;
         if (seq_start) auto_q <= !pop;
         if (man_rd)    rd_reg <= done_word;

         if (reg_wr && reg_addr == A_CTRL) begin
            pg512  <= reg_wdata[0];
            wide   <= wide_in;
            rd_dly <= reg_wdata[RD_LO +: DLY_W];
            wr_dly <= reg_wdata[WR_LO +: DLY_W];
         end

         if (reg_wr && reg_addr == A_RST && reg_wdata[0]) rst_pend <= 1'b1;
         else if (!seq_busy)                              rst_pend <= 1'b0;

         if (reg_wr && reg_addr == A_PAGE && !pg_rd && !pg_wr) begin
            if (reg_wdata[0]) begin
               pg_rd  <= 1'b1;
               pg_cnt <= '0;
            end else if (reg_wdata[1]) begin
               pg_wr  <= 1'b1;
               pg_cnt <= '0;
            end
         end else if (page_end) begin
            pg_cnt <= '0;
            if (done_op == OP_READ) pg_rd <= 1'b0;
            else                    pg_wr <= 1'b0;
         end else if (page_beat) begin
            pg_cnt <= pg_cnt + 1'b1;
         end else if (ecc_clr) begin
            pg_cnt <= '0;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: begin
            reg_rdata[0]              = pg512;
            reg_rdata[1]              = wide;
            reg_rdata[RD_LO +: DLY_W] = rd_dly;
            reg_rdata[WR_LO +: DLY_W] = wr_dly;
         end
         A_STAT:  reg_rdata[FLAG_N-1:0] = {wb_empty, pg_rd, pg_wr, wb_full, rb_level};
         A_IRQ:   reg_rdata[FLAG_N-1:0] = irq;
         A_RST:   reg_rdata[0] = rst_pend;
         A_RDATA: reg_rdata[DQ_W-1:0] = rd_reg;
         default: reg_rdata = '0;
      endcase
   end

   // R3
   ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && wb_full && !pop) |=> irq[1]);
   // R4
   rd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      man_rd |=> irq[3]);
   // R8
   rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_pend && !seq_busy && !(reg_wr && reg_addr == A_RST)) |=> !rst_pend);
   // R10
   pg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pg_rd && pg_wr));
   // R9
   auto_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ecc_valid && done_op == OP_READ) |-> pg_rd);

endmodule

// File: tb/nand_ctrl_front_bench.sv
module nand_ctrl_front_bench;
   localparam logic [3:0] R_CTRL = 4'd0, R_STAT = 4'd1, R_IRQ = 4'd2, R_RST = 4'd3,
                          R_PAGE = 4'd4, R_CMD = 4'd5, R_ADDR = 4'd6, R_DWR = 4'd7,
                          R_DRD = 4'd8, R_RDATA = 4'd9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [15:0] nand_dq_o, nand_dq_i;
   logic        nand_rb = 1'b0;
   logic        ecc_clr, ecc_valid;
   logic [15:0] ecc_word;

   always #10 clk = ~clk;

   int checks = 0, fails = 0;
   int rcount = 0, ecc_beats = 0, clr_seen = 0, lowcnt = 0;
   int exp_wr = 0, exp_rd = 0;
   bit wide_m = 0, pg_rd_m = 0;
   string cur_req = "R2";
   logic [17:0] exp_q[$];
   logic [17:0] cap, e;
   logic prev_we = 1'b1, prev_re = 1'b1;

   function automatic logic [15:0] model(int n);
      return 16'hA55A ^ 16'(n * 259);
   endfunction

   function automatic logic [15:0] msk(logic [15:0] v);
      return wide_m ? v : {8'h00, v[7:0]};
   endfunction

   assign nand_dq_i = model(rcount);

   nand_ctrl_front u_nand_ctrl_front (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nand_cle(nand_cle),
      .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
      .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
      .nand_rb(nand_rb), .ecc_clr(ecc_clr), .ecc_valid(ecc_valid), .ecc_word(ecc_word)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: pops expected strobes and compares as the pins produce them
   always @(negedge clk) begin
      if (rst_n) begin
         if (ecc_clr) clr_seen++;
         if (ecc_valid) begin
            ecc_beats++;
            if (pg_rd_m) check("R9", ecc_word, msk(model(rcount)), "page read word");
         end
         if (!nand_we_n || !nand_re_n) begin
            lowcnt++;
            cap = {nand_cle, nand_ale, nand_dq_o};
         end
         if (!prev_we && nand_we_n) begin
            if (exp_q.size() == 0) check(cur_req, 1, 0, "unexpected write strobe");
            else begin
               e = exp_q.pop_front();
               check(cur_req, cap, e, "strobe latch/bus");
            end
            check("R2", lowcnt, exp_wr + 1, "write strobe low width");
            lowcnt = 0;
         end
         if (!prev_re && nand_re_n) begin
            check("R4", lowcnt, exp_rd + 1, "read strobe low width");
            lowcnt = 0;
            rcount++;
         end
         prev_we = nand_we_n;
         prev_re = nand_re_n;
      end
   end

   task automatic reg_write(logic [3:0] a, logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1 reg_wr = 1'b0;
   endtask

   task automatic reg_read(logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic set_ctrl(bit p512, bit wd, int rd, int wr);
      reg_write(R_CTRL, 16'(p512) | (16'(wd) << 1) | (16'(rd) << 2) | (16'(wr) << 6));
      exp_rd = rd; exp_wr = wr; wide_m = wd;
   endtask

   task automatic send(logic [3:0] a, logic [15:0] d, bit cle, bit ale, logic [15:0] bus);
      logic [15:0] s;
      int guard = 0;
      reg_read(R_STAT, s);
      while (s[1] && guard < 2000) begin
         reg_read(R_STAT, s);
         guard++;
      end
      exp_q.push_back({cle, ale, bus});
      reg_write(a, d);
   endtask

   task automatic wait_drain();
      int guard = 0;
      while ((exp_q.size() != 0 || !nand_we_n || !nand_re_n) && guard < 5000) begin
         @(posedge clk);
         guard++;
      end
      repeat (4) @(posedge clk);
   endtask

   task automatic wait_stat_clear(int bitn);
      logic [15:0] s;
      int guard = 0;
      reg_read(R_STAT, s);
      while (s[bitn] && guard < 5000) begin
         reg_read(R_STAT, s);
         guard++;
      end
   endtask

   task automatic single_read(string req);
      logic [15:0] v, expv;
      int guard = 0;
      expv = msk(model(rcount));
      reg_write(R_DRD, 16'h5A5A);
      reg_read(R_IRQ, v);
      while (!v[3] && guard < 200) begin
         reg_read(R_IRQ, v);
         guard++;
      end
      check(req, v[3], 1, "read ready flag");
      reg_read(R_RDATA, v);
      check(req, v, expv, "read result");
      reg_write(R_IRQ, 16'h0008);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [15:0] v;
      int base;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (2) @(posedge clk);

      // R1 reset state
      reg_read(R_STAT, v); check("R1", v, 16'h0010, "status after reset");
      reg_read(R_IRQ, v);  check("R1", v, 16'h0000, "irq after reset");
      reg_read(R_RST, v);  check("R1", v, 16'h0000, "reset reg after reset");
      check("R1", {nand_we_n, nand_re_n, nand_cle, nand_ale}, 4'b1100, "idle pins");

      // R7 ready/busy
      @(negedge clk) nand_rb = 1'b1;
      repeat (4) @(posedge clk);
      reg_read(R_STAT, v); check("R7", v[0], 1, "synced ready level");
      reg_read(R_IRQ, v);  check("R7", v[0], 1, "ready rise flag");
      @(negedge clk) nand_rb = 1'b0;
      repeat (4) @(posedge clk);
      reg_read(R_STAT, v); check("R7", v[0], 0, "synced busy level");

      // R5 write-one-to-clear
      reg_write(R_IRQ, 16'h0000);
      reg_read(R_IRQ, v); check("R5", v[0], 1, "zero write keeps flag");
      reg_write(R_IRQ, 16'h0001);
      reg_read(R_IRQ, v); check("R5", v[0], 0, "one write clears flag");

      // R2 command / address / data strobes, 8-bit mode
      set_ctrl(0, 0, 2, 3);
      reg_read(R_CTRL, v); check("R2", v, 16'h00C8, "control readback");
      cur_req = "R2";
      send(R_CMD, 16'h0070, 1, 0, 16'h0070);
      send(R_ADDR, 16'h01A5, 0, 1, 16'h00A5);
      send(R_DWR, 16'hBEEF, 0, 0, 16'h00EF);
      wait_drain();
      // R6 drain edge
      reg_read(R_IRQ, v); check("R6", v[2], 1, "buffer drained flag");
      reg_write(R_IRQ, 16'h0004);
      reg_read(R_IRQ, v); check("R5", v[2], 0, "drain flag cleared");

      // R4 single read, 8-bit
      single_read("R4");

      // R3 overflow: six back-to-back pushes, sixth dropped
      set_ctrl(0, 0, 0, 15);
      cur_req = "R3";
      for (int i = 0; i < 5; i++) exp_q.push_back({1'b0, 1'b0, 16'(8'h30 + i)});
      for (int i = 0; i < 6; i++) reg_write(R_DWR, 16'(16'h0030 + i));
      reg_read(R_STAT, v); check("R3", v[1], 1, "buffer full status");
      check("R3", v[4], 0, "buffer not empty");
      reg_read(R_IRQ, v); check("R3", v[1], 1, "overflow flag");
      wait_drain();
      repeat (20) @(posedge clk);
      check("R3", exp_q.size(), 0, "strobes left over");
      reg_write(R_IRQ, 16'h001F);

      // R8 self-clearing reset
      base = clr_seen;
      reg_write(R_RST, 16'h0001);
      reg_read(R_RST, v); check("R8", v[0], 1, "reset bit pending");
      repeat (3) @(posedge clk);
      reg_read(R_RST, v); check("R8", v[0], 0, "reset bit cleared");
      check("R8", clr_seen - base, 1, "ecc clear pulses");

      // R9 page read, 256 bytes, 8-bit
      set_ctrl(0, 0, 0, 0);
      base = ecc_beats; pg_rd_m = 1;
      reg_write(R_PAGE, 16'h0001);
      reg_read(R_STAT, v); check("R9", v[3], 1, "page read pending");
      wait_stat_clear(3);
      repeat (4) @(posedge clk);
      pg_rd_m = 0;
      check("R9", ecc_beats - base, 256, "beats in 256-byte section");
      reg_read(R_IRQ, v); check("R9", v[3], 0, "no read-ready flag on page");

      // R9 page read, 512 bytes, 8-bit, with read delay
      set_ctrl(1, 0, 1, 0);
      base = ecc_beats; pg_rd_m = 1;
      reg_write(R_PAGE, 16'h0001);
      wait_stat_clear(3);
      repeat (4) @(posedge clk);
      pg_rd_m = 0;
      check("R9", ecc_beats - base, 512, "beats in 512-byte section");

      // R10 page write, 512 bytes, 16-bit
      set_ctrl(1, 1, 0, 0);
      cur_req = "R10";
      base = ecc_beats;
      reg_write(R_PAGE, 16'h0002);
      reg_read(R_STAT, v); check("R10", v[2], 1, "page write pending");
      reg_write(R_PAGE, 16'h0001);
      reg_read(R_STAT, v); check("R10", v[3], 0, "page read refused while writing");
      for (int i = 0; i < 256; i++) begin
         logic [15:0] w;
         w = 16'(i * 16'h0101) ^ 16'h1234;
         send(R_DWR, w, 0, 0, w);
      end
      wait_drain();
      reg_read(R_STAT, v); check("R10", v[2], 0, "page write pending cleared");
      reg_read(R_IRQ, v);  check("R10", v[4], 1, "page write done flag");
      check("R10", ecc_beats - base, 256, "beats in 16-bit section");

      // R4 single read, 16-bit
      single_read("R4");
      cur_req = "R2";
      send(R_CMD, 16'hFF90, 1, 0, 16'h0090);
      wait_drain();
      check("R2", exp_q.size(), 0, "scoreboard empty");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule